// File: doc/BRIEF.md
# Strobed Memory Bus Cycle Sequencer

This block sits on the host side of a static memory whose address is captured on the falling edge of an active-low enable strobe and whose data pins are a single shared bidirectional bus. A client issues one access at a time through a valid/write/address/data request. The sequencer turns each request into a strobe cycle that meets the memory's timing, and then reports completion with a one-cycle done pulse. A read also returns its data with that pulse.

Every interval is a parameter counted in clock cycles. These are the address setup before the strobe falls, the address hold after it falls, the minimum low and high strobe widths, the read access delay, and the write-data setup and hold around the strobe's rising edge. Writes always lower write-enable before the strobe falls and raise it only after the strobe has risen, so the memory never drives the shared bus during a write. Consecutive writes keep write-enable low and pulse the strobe once per location. A read that follows a write burst first raises write-enable. The pad-level tristate is built outside from `mem_wdata`, `mem_drive` and `mem_rdata`.

Top module: `strobe_mem_seq`

## Requirements
- R1: During and right after reset: `mem_en_n`=1, `mem_we_n`=1, `mem_drive`=0, `rsp_done`=0 and `req_ready`=1.
- R2: `mem_addr` is stable for more than T_ASU clock cycles before `mem_en_n` falls, and it does not change while `mem_en_n` is low. This covers the T_AH hold.
- R3: `mem_en_n` stays low for at least T_EL cycles and high for at least T_EH cycles between low pulses.
- R4: On a read, `mem_we_n` is 1 for the whole low strobe and `mem_drive` stays 0. `mem_rdata` is captured at least T_ACC cycles after the strobe falls, and `rsp_rdata` equals the value last written to that address.
- R5: On a write, `mem_we_n` is already low in the cycle before the strobe falls, and `mem_we_n` never rises while `mem_en_n` is low. The memory stores `mem_wdata` at the strobe's rising edge, once per accepted write.
- R6: `mem_drive` is 1 only while `mem_we_n` is 0. Write data is driven and stable for more than T_DSU cycles before the strobe rises, and for T_DH cycles after it rises (a minimum of one).
- R7: Back-to-back writes keep `mem_we_n` low between accesses, and `mem_en_n` falls exactly once per write.
- R8: A read that follows writes raises `mem_we_n` before its strobe falls, and the high-width rule of R3 still holds.
- R9: Each accepted request yields exactly one `rsp_done` pulse, one cycle wide. `req_ready` is 0 from the cycle after acceptance until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with the done pulse of a read |
| mem_en_n | output | 1 | Active-low strobe; address captured on its falling edge |
| mem_we_n | output | 1 | Active-low write-enable |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_wdata | output | DATA_W | Data toward the shared bus |
| mem_drive | output | 1 | Output enable of the host bus driver |
| mem_rdata | input | DATA_W | Data read from the shared bus |

## Verification
If the phase counter were loaded short, the strobe would rise early. A read would then sample data the memory has not yet produced, so a wrong `rsp_rdata` would appear with the very next done pulse. A stale write-enable or drive flag would show up within a single access as bus contention, or as a write that commits at the wrong strobe edge. The bench memory model flags contention in the same cycle, and the wrong stored value is caught by the next read of that address. A lost or repeated done pulse shows at once as a mismatch between the pulse count and the number of accepted requests.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // after a load the count must fall by one each cycle until zero
    assert_timer_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/seq_high_meter.sv
module seq_high_meter #(
    parameter int unsigned LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic met
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!strobe_n)              cnt_d = '0;
        else if (cnt_q < W'(LIMIT)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(LIMIT);
        else        cnt_q <= cnt_d;
    end

    // completed high cycles plus the current one reach LIMIT
    assign met = (cnt_q >= W'(LIMIT - 1));

endmodule

// File: rtl/strobe_mem_seq.sv
module strobe_mem_seq
    import strobe_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 4,
    parameter int unsigned T_ASU  = 1,
    parameter int unsigned T_AH   = 4,
    parameter int unsigned T_EL   = 12,
    parameter int unsigned T_EH   = 5,
    parameter int unsigned T_ACC  = 12,
    parameter int unsigned T_DSU  = 5,
    parameter int unsigned T_DH   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_en_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_drive,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned S_CYC = umax(T_ASU, 1);
    localparam int unsigned L_RD  = umax(umax(T_EL, T_ACC), umax(T_AH, 1));
    localparam int unsigned L_WR  = umax(umax(T_EL, T_DSU), umax(T_AH, 1));
    localparam int unsigned H_CYC = umax(T_DH, 1);
    localparam int unsigned SPAN  = umax(umax(S_CYC, L_RD), umax(L_WR, H_CYC));
    localparam int unsigned CNT_W = $clog2(SPAN + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              en_n;
        logic              we_n;
        logic              drive;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t        q, d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             high_met;

    seq_interval_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    seq_high_meter #(.LIMIT(umax(T_EH, 1))) u_high (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (q.en_n),
        .met      (high_met)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                    d.wr     = req_write;
                    d.we_n   = ~req_write;   // a read ends any write burst here
                    d.drive  = req_write;
                    d.st     = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(S_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero && high_met) begin
                    d.en_n   = 1'b0;
                    d.st     = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = q.wr ? CNT_W'(L_WR - 1) : CNT_W'(L_RD - 1);
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    d.en_n = 1'b1;
                    if (q.wr) begin
                        d.st     = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(H_CYC - 1);
                    end else begin
                        d.rdata = mem_rdata;
                        d.done  = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    d.drive = 1'b0;   // write-enable stays low for a possible burst
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, addr: '0, wdata: '0, wr: 1'b0, en_n: 1'b1,
                   we_n: 1'b1, drive: 1'b0, done: 1'b0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_done  = q.done;
    assign rsp_rdata = q.rdata;
    assign mem_en_n  = q.en_n;
    assign mem_we_n  = q.we_n;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign mem_drive = q.drive;

    // ---------------- assertions ----------------
    logic [31:0] lo_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     lo_run_q <= '0;
        else if (mem_en_n)              lo_run_q <= '0;
        else if (lo_run_q != 32'hFFFF)  lo_run_q <= lo_run_q + 1'b1;
    end

    assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en_n) |-> (lo_run_q >= 32'(T_EL)));

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_addr));

    assert_read_we_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en_n && !q.wr) |-> (mem_we_n && !mem_drive));

    assert_we_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_en_n) && q.wr) |-> (!mem_we_n && $past(!mem_we_n)));

    assert_we_rise_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_en_n && !mem_drive));

    assert_drive_needs_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drive |-> !mem_we_n);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/sim_strobe_mem_seq.sv
module sim_strobe_mem_seq;
    localparam int CLK_NS = 10;
    localparam int AW = 10, DW = 4;
    localparam int ASU = 1, AH = 4, EL = 12, EH = 5, ACC = 12, DSU = 5, DH = 1;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_done, mem_en_n, mem_we_n, mem_drive;
    logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    always #(CLK_NS/2) clk = ~clk;

    strobe_mem_seq #(.ADDR_W(AW), .DATA_W(DW), .T_ASU(ASU), .T_AH(AH), .T_EL(EL),
                     .T_EH(EH), .T_ACC(ACC), .T_DSU(DSU), .T_DH(DH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_en_n(mem_en_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_drive(mem_drive), .mem_rdata(mem_rdata));

    int n_checks = 0, n_fail = 0;
    bit reported = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // ---------------- memory model and bus monitor ----------------
    logic [DW-1:0] arr [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    int low_cyc = 0, high_cyc = 1000, addr_age = 0, data_age = 0, hold_left = 0;
    logic prev_en_n = 1'b1, prev_we_n = 1'b1, prev_done = 1'b0, cyc_is_read = 1'b1;
    logic [AW-1:0] prev_addr = '0, lat = '0;
    logic [DW-1:0] prev_wd = '0, held_wd = '0;
    int v_setup = 0, v_hold = 0, v_el = 0, v_eh = 0, v_rd_we = 0, v_order = 0;
    int v_dsu = 0, v_dh = 0, v_drive = 0, v_done_wide = 0, v_busy = 0;
    int n_fall = 0, n_we_rise = 0, n_commit = 0, n_done_seen = 0;

    // data is valid only after the access delay; earlier it is the inverse
    assign mem_rdata = (!mem_en_n && mem_we_n && low_cyc >= ACC) ? arr[lat] : ~arr[lat];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin arr[i] = '0; shadow[i] = '0; end
    end

    always @(negedge clk) if (rst_n) begin
        addr_age = (mem_addr == prev_addr) ? addr_age + 1 : 1;
        data_age = !mem_drive ? 0 : ((mem_wdata == prev_wd) ? data_age + 1 : 1);
        if (!mem_en_n && prev_en_n) begin
            n_fall++;
            lat = mem_addr;
            cyc_is_read = mem_we_n;
            if (addr_age <= ASU) v_setup++;
            if (high_cyc < EH) v_eh++;
            if (!mem_we_n && prev_we_n) v_order++;
            low_cyc = 1;
        end else if (!mem_en_n) begin
            low_cyc++;
            if (mem_addr != lat) v_hold++;
            if (cyc_is_read && !mem_we_n) v_rd_we++;
        end
        if (mem_en_n && !prev_en_n) begin
            if (low_cyc < EL) v_el++;
            if (!mem_we_n) begin
                if (!mem_drive || data_age <= DSU) v_dsu++;
                arr[lat] = mem_wdata;
                n_commit++;
                held_wd = mem_wdata;
                hold_left = DH - 1;
            end else if (!cyc_is_read) v_order++;
            high_cyc = 1;
        end else if (mem_en_n) begin
            if (high_cyc < 1000) high_cyc++;
            if (hold_left > 0) begin
                if (!mem_drive || mem_wdata != held_wd) v_dh++;
                hold_left--;
            end
        end
        if (mem_drive && mem_we_n) v_drive++;
        if (mem_we_n && !prev_we_n) begin
            n_we_rise++;
            if (!mem_en_n) v_order++;
        end
        if (rsp_done) n_done_seen++;
        if (rsp_done && prev_done) v_done_wide++;
        prev_done = rsp_done;
        prev_en_n = mem_en_n;
        prev_we_n = mem_we_n;
        prev_addr = mem_addr;
        prev_wd   = mem_wdata;
    end

    // ---------------- stimulus ----------------
    int n_issued = 0, n_writes = 0;

    task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] dat);
        int guard;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        @(negedge clk);
        req_valid = 1'b0;
        n_issued++;
        guard = 0;
        while (!rsp_done && guard < 200) begin
            if (req_ready) v_busy++;
            @(negedge clk);
            guard++;
        end
        check(rsp_done, "R9 done timeout", int'(rsp_done), 1);
        if (wr) begin
            shadow[a] = dat;
            n_writes++;
        end else begin
            check(rsp_rdata == shadow[a], "R4 read data", int'(rsp_rdata), int'(shadow[a]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int f0, r0;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        // R1: reset state, in reset and just after release
        check(mem_en_n && mem_we_n && !mem_drive && !rsp_done, "R1 in reset",
              int'({mem_en_n, mem_we_n, mem_drive, rsp_done}), 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_en_n && mem_we_n && !mem_drive && !rsp_done && req_ready, "R1 after release",
              int'({mem_en_n, mem_we_n, mem_drive, rsp_done, req_ready}), 5'b11001);

        // R7: burst of writes keeps write-enable low, one strobe per location
        f0 = n_fall; r0 = n_we_rise;
        do_op(1'b1, 10'h000, 4'h5);
        do_op(1'b1, 10'h3FF, 4'hA);
        do_op(1'b1, 10'h155, 4'hF);
        do_op(1'b1, 10'h2AA, 4'h0);
        check(n_we_rise == r0, "R7 we_n held low in burst", n_we_rise - r0, 0);
        check(n_fall - f0 == 4, "R7 one strobe per write", n_fall - f0, 4);
        repeat (3) @(negedge clk);
        check(!mem_we_n, "R7 we_n still low when idle", int'(mem_we_n), 0);

        // R8: read after the burst raises write-enable first
        r0 = n_we_rise;
        do_op(1'b0, 10'h3FF, 4'h0);
        check(n_we_rise - r0 == 1, "R8 we_n raised for read", n_we_rise - r0, 1);
        do_op(1'b0, 10'h000, 4'h0);
        do_op(1'b0, 10'h155, 4'h0);
        do_op(1'b1, 10'h155, 4'h3);   // overwrite, then read back (R5)
        do_op(1'b0, 10'h155, 4'h0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic wr;
            logic [AW-1:0] a;
            wr = 1'($urandom % 2);
            a  = (($urandom % 4) == 0) ? AW'($urandom % DEPTH) : AW'($urandom % 16);
            do_op(wr, a, DW'($urandom));
        end
        repeat (5) @(negedge clk);

        check(v_setup == 0, "R2 address setup", v_setup, 0);
        check(v_hold == 0, "R2 address hold", v_hold, 0);
        check(v_el == 0, "R3 low width", v_el, 0);
        check(v_eh == 0, "R3 R8 high width", v_eh, 0);
        check(v_rd_we == 0, "R4 we_n high in read", v_rd_we, 0);
        check(v_order == 0, "R5 strobe/we ordering", v_order, 0);
        check(n_commit == n_writes, "R5 one commit per write", n_commit, n_writes);
        check(v_drive == 0, "R6 drive only with we_n low", v_drive, 0);
        check(v_dsu == 0, "R6 data setup", v_dsu, 0);
        check(v_dh == 0, "R6 data hold", v_dh, 0);
        check(v_done_wide == 0, "R9 done one cycle", v_done_wide, 0);
        check(n_done_seen == n_issued, "R9 done per request", n_done_seen, n_issued);
        check(v_busy == 0, "R9 ready low while busy", v_busy, 0);
        report();
    end
endmodule